// File: doc/BRIEF.md
# Palette Colour Lookup CPU Port

This block holds a 256-entry colour lookup table of 18-bit colours, each kept as three 6-bit components (red, green, blue). It gives a processor byte-wide access to the table through four port addresses: one to start a read sequence, one to start a write sequence, a shared data port, and a reserved address. The data port moves one component per access. A sub-component counter steps red, then green, then blue. After the third component the entry index moves to the next entry, so software can load or dump a run of entries with one index setup.

A pixel-side port runs beside the processor interface. It takes an 8-bit pixel index and returns that entry's 18-bit colour one clock later. The pixel port never disturbs processor sequences.

Writes are staged. Red and green wait in holding registers, and all three components land in storage together when blue is written. A display scanning the table therefore never sees a half-updated colour.

Top module: `pal_dac_port`

## Requirements
- R1: After reset every entry is zero, the entry index is 0 and the block is in write mode. Reading address 0 returns 8'h00, reading address 1 returns 8'h00, and the pixel port returns 18'h0.
- R2: A processor write to address 1 loads the entry index from the write data and selects write mode. Afterwards, reading address 1 returns that index and reading address 0 returns 8'h00 (bits 1:0 = 00 means write mode, upper bits zero).
- R3: In write mode, three data writes (address 2) supply red, green and blue in that order, and only bits 5:0 of each byte are kept. The entry {red[17:12], green[11:6], blue[5:0]} changes in storage only on the blue write; after the red and green writes alone it still holds its old value.
- R4: Each committed write triplet advances the entry index by one, wrapping from 255 to 0.
- R5: A processor write to address 0 loads the entry index and selects read mode. Reading address 0 then returns 8'h03 (bits 1:0 = 11). Three data reads return red, green and blue in bits 5:0 with bits 7:6 zero, and the third read advances the index by one, wrapping from 255 to 0.
- R6: A write to either index port (address 0 or 1) returns the component counter to red, discarding a partly entered triplet.
- R7: The pixel port returns the colour of the entry selected by the pixel index one clock later. If the same entry is committed in that same clock, the pixel port returns the value the entry held before the commit.
- R8: A data access that does not match the mode has no effect. A data write in read mode changes neither storage nor the index. A data read in write mode returns 8'h00 and does not advance the counter or the index.
- R9: When a write and a read are requested in the same cycle, only the write acts. Address 3 reads 8'h00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe, one access per cycle |
| cpu_rd | input | 1 | Processor read strobe, side effects at the clock edge |
| cpu_addr | input | 2 | Port select: 0 read-index/state, 1 write-index/index, 2 data, 3 reserved |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data for the selected address (combinational) |
| pix_idx | input | 8 | Pixel-side entry index |
| pix_rgb | output | 18 | Colour of the entry selected one cycle earlier, {red, green, blue} |

## Verification
Each kind of wrong internal state shows at the ports in a predictable way:

- **Component counter out of step:** the colour written to the data port lands in the wrong field. This shows on the pixel port one cycle after the blue write, and also on the next read sequence.
- **Index that fails to step or wrap:** this is visible on address 1 right after the third access.
- **Wrong mode flag:** it shows at once on address 0. It also shows as a data read returning a component in write mode, or as a data write in read mode altering an entry.
- **Premature commit:** this appears on the pixel port in the cycle after the red or green write.

// File: rtl/pal_dac_pkg.sv
// Package: shared constants and types for the palette CPU port.
// Assumes a byte-wide processor bus and three colour components per entry.
package pal_dac_pkg;

    // Processor port addresses
    localparam logic [1:0] P_RIDX = 2'd0;  // write: read-sequence index, read: state
    localparam logic [1:0] P_WIDX = 2'd1;  // write: write-sequence index, read: index
    localparam logic [1:0] P_DATA = 2'd2;  // component data
    localparam logic [1:0] P_RSVD = 2'd3;  // reserved

    // State codes returned on P_RIDX reads
    localparam logic [1:0] ST_WRITE = 2'b00;
    localparam logic [1:0] ST_READ  = 2'b11;

    // Sub-component counter
    typedef enum logic [1:0] {
        C_RED   = 2'd0,
        C_GREEN = 2'd1,
        C_BLUE  = 2'd2
    } comp_e;

endpackage

// File: rtl/pal_dac_seq.sv
// Module: pal_dac_seq
// Sequencing for processor accesses: holds the entry index, the read/write mode
// flag, the component counter and the red/green staging registers. It issues a
// one-cycle commit with the full entry when blue is written.
// Assumes: a write and a read in the same cycle are resolved in favour of the write.
module pal_dac_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [1:0]           cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [IDX_W-1:0]     idx,
    output logic                 rd_mode,
    output comp_e                cnt,
    output logic                 commit,
    output logic [3*COMP_W-1:0]  commit_data
);

    logic [COMP_W-1:0] stage_r;
    logic [COMP_W-1:0] stage_g;
    logic              wr_acc;
    logic              rd_acc;
    logic              data_wr;
    logic              data_rd;
    logic              step;

    // Qualify the strobes and decode the data-port accesses that match the mode
    always_comb begin
        wr_acc  = cpu_wr;
        rd_acc  = cpu_rd && !cpu_wr;
        data_wr = wr_acc && (cpu_addr == P_DATA) && !rd_mode;
        data_rd = rd_acc && (cpu_addr == P_DATA) && rd_mode;
        step    = data_wr || data_rd;
    end

    // Blue write completes the entry
    assign commit      = data_wr && (cnt == C_BLUE);
    assign commit_data = {stage_r, stage_g, cpu_wdata[COMP_W-1:0]};

    // Index, mode and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            rd_mode <= 1'b0;
            cnt     <= C_RED;
        end else if (wr_acc && cpu_addr == P_RIDX) begin
            idx     <= cpu_wdata[IDX_W-1:0];
            rd_mode <= 1'b1;
            cnt     <= C_RED;
        end else if (wr_acc && cpu_addr == P_WIDX) begin
            idx     <= cpu_wdata[IDX_W-1:0];
            rd_mode <= 1'b0;
            cnt     <= C_RED;
        end else if (step) begin
            case (cnt)
                C_RED:   cnt <= C_GREEN;
                C_GREEN: cnt <= C_BLUE;
                default: begin
                    cnt <= C_RED;
                    idx <= idx + 1'b1;
                end
            endcase
        end
    end

    // Staging of red and green until blue arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_r <= '0;
            stage_g <= '0;
        end else if (data_wr) begin
            if (cnt == C_RED)   stage_r <= cpu_wdata[COMP_W-1:0];
            if (cnt == C_GREEN) stage_g <= cpu_wdata[COMP_W-1:0];
        end
    end

endmodule

// File: rtl/pal_dac_ram.sv
// Module: pal_dac_ram
// Colour table storage with one synchronous write port, a combinational processor
// read port and a registered pixel read port. A pixel read of an entry written in
// the same cycle returns the previous contents.
// Assumes: the table is small enough to be held in flops with a reset to zero.
module pal_dac_ram #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   cpu_raddr,
    output logic [ENTRY_W-1:0] cpu_rentry,
    input  logic [IDX_W-1:0]   pix_raddr,
    output logic [ENTRY_W-1:0] pix_rentry
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Table storage: clear on reset, write on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Pixel port: one-cycle registered read
    always_ff @(posedge clk) begin
        if (!rst_n) pix_rentry <= '0;
        else        pix_rentry <= mem[pix_raddr];
    end

    // Processor port: combinational read of the current entry
    assign cpu_rentry = mem[cpu_raddr];

endmodule

// File: rtl/pal_dac_rdmux.sv
// Module: pal_dac_rdmux
// Processor read-data selection: state code, current index, or the component
// picked by the counter (read mode only). Unused bits read as zero.
// Assumes: DATA_W is at least IDX_W and COMP_W.
module pal_dac_rdmux
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int DATA_W = 8
) (
    input  logic [1:0]          cpu_addr,
    input  logic                rd_mode,
    input  logic [IDX_W-1:0]    idx,
    input  comp_e               cnt,
    input  logic [3*COMP_W-1:0] entry,
    output logic [DATA_W-1:0]   rdata
);

    logic [COMP_W-1:0] comp;

    // Pick the component addressed by the counter
    always_comb begin
        case (cnt)
            C_RED:   comp = entry[3*COMP_W-1 -: COMP_W];
            C_GREEN: comp = entry[2*COMP_W-1 -: COMP_W];
            default: comp = entry[COMP_W-1:0];
        endcase
    end

    // Address decode for the read data
    always_comb begin
        rdata = '0;
        case (cpu_addr)
            P_RIDX:  rdata[1:0] = rd_mode ? ST_READ : ST_WRITE;
            P_WIDX:  rdata[IDX_W-1:0] = idx;
            P_DATA:  if (rd_mode) rdata[COMP_W-1:0] = comp;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pal_dac_port.sv
// Module: pal_dac_port (top)
// Processor access port and pixel lookup for a colour table of 2**IDX_W entries
// of three COMP_W-bit components. Connects sequencing, storage and read decode.
// Assumes: synchronous active-low reset, one processor access per cycle.
module pal_dac_port
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [1:0]           cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    input  logic [IDX_W-1:0]     pix_idx,
    output logic [3*COMP_W-1:0]  pix_rgb
);

    localparam int ENTRY_W = 3 * COMP_W;

    logic [IDX_W-1:0]   idx_q;
    logic               rd_mode_q;
    comp_e              cnt_q;
    logic               commit;
    logic [ENTRY_W-1:0] commit_data;
    logic [ENTRY_W-1:0] cpu_entry;

    // Access sequencing
    pal_dac_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .idx         (idx_q),
        .rd_mode     (rd_mode_q),
        .cnt         (cnt_q),
        .commit      (commit),
        .commit_data (commit_data)
    );

    // Colour storage
    pal_dac_ram #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (commit),
        .waddr      (idx_q),
        .wdata      (commit_data),
        .cpu_raddr  (idx_q),
        .cpu_rentry (cpu_entry),
        .pix_raddr  (pix_idx),
        .pix_rentry (pix_rgb)
    );

    // Processor read data
    pal_dac_rdmux #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_rdmux (
        .cpu_addr (cpu_addr),
        .rd_mode  (rd_mode_q),
        .idx      (idx_q),
        .cnt      (cnt_q),
        .entry    (cpu_entry),
        .rdata    (cpu_rdata)
    );

endmodule

// File: rtl/pal_dac_port_chk.sv
// Module: pal_dac_port_chk
// Temporal checks on the palette port, bound into every pal_dac_port instance.
module pal_dac_port_chk #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [1:0]        cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [IDX_W-1:0]  idx,
    input logic              rd_mode,
    input logic [1:0]        cnt
);

    // R2: write-index port loads index and selects write mode
    a_r2_widx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd1) |=> (idx == $past(cpu_wdata[IDX_W-1:0]) && !rd_mode));

    // R5: read-index port loads index and selects read mode
    a_r5_ridx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd0) |=> (idx == $past(cpu_wdata[IDX_W-1:0]) && rd_mode));

    // R4: a committed triplet advances the index with wrap
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd2 && !rd_mode && cnt == 2'd2)
        |=> (idx == IDX_W'($past(idx) + 1'b1)));

    // R6: any index-port write restarts at red
    a_r6_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr == 2'd0 || cpu_addr == 2'd1)) |=> (cnt == 2'd0));

    // R8: data reads in write mode return zero and move nothing
    a_r8_wmode_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_mode && cpu_addr == 2'd2) |-> (cpu_rdata == '0));

    a_r8_wmode_read_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_mode && cpu_rd && !cpu_wr && cpu_addr == 2'd2) |=> ($stable(idx) && $stable(cnt)));

    // R9: reserved address reads zero
    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 2'd3) |-> (cpu_rdata == '0));

endmodule

bind pal_dac_port pal_dac_port_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .idx       (idx_q),
    .rd_mode   (rd_mode_q),
    .cnt       (cnt_q)
);

// File: tb/pal_dac_port_tb.sv
// Bench for pal_dac_port: a vector table walk, then directed corner tests.
module pal_dac_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pal_dac_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    // Vector: [19:18] op (0 write, 1 read+check), [17:16] addr, [15:8] wdata, [7:0] expected
    localparam logic [19:0] VEC [12] = '{
        {2'd0, 2'd1, 8'h10, 8'h00},  // R2 write index 0x10
        {2'd0, 2'd2, 8'hC5, 8'h00},  // R3 red, bits 7:6 dropped
        {2'd0, 2'd2, 8'h2A, 8'h00},  // R3 green
        {2'd0, 2'd2, 8'h11, 8'h00},  // R3 blue, commit
        {2'd1, 2'd1, 8'h00, 8'h11},  // R4 index stepped
        {2'd1, 2'd0, 8'h00, 8'h00},  // R2 state write
        {2'd0, 2'd0, 8'h10, 8'h00},  // R5 read index 0x10
        {2'd1, 2'd0, 8'h00, 8'h03},  // R5 state read
        {2'd1, 2'd2, 8'h00, 8'h05},  // R5 red
        {2'd1, 2'd2, 8'h00, 8'h2A},  // R5 green
        {2'd1, 2'd2, 8'h00, 8'h11},  // R5 blue
        {2'd1, 2'd1, 8'h00, 8'h11}   // R5 index stepped
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check18(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1;
        check8(req, cpu_rdata, exp);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic pix_check(input string req, input logic [7:0] e, input logic [17:0] exp);
        @(negedge clk);
        pix_idx = e;
        @(negedge clk);
        check18(req, pix_rgb, exp);
    endtask

    // Watchdog
    initial begin
        #1000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cpu_read("R1 state", 2'd0, 8'h00);
        cpu_read("R1 index", 2'd1, 8'h00);
        pix_check("R1 pixel", 8'h7E, 18'h0);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][19:18] == 2'd0) cpu_write(VEC[i][17:16], VEC[i][15:8]);
            else cpu_read("R2/R3/R4/R5 vector", VEC[i][17:16], VEC[i][7:0]);
        end
        pix_check("R3 committed entry", 8'h10, 18'h05A91);

        // R4 / R5: wrap at 255
        cpu_write(2'd1, 8'hFF);
        cpu_write(2'd2, 8'h01);
        cpu_write(2'd2, 8'h02);
        cpu_write(2'd2, 8'h03);
        cpu_read("R4 wrap index", 2'd1, 8'h00);
        pix_check("R4 entry 255", 8'hFF, 18'h01083);
        cpu_write(2'd0, 8'hFF);
        cpu_read("R5 red 255", 2'd2, 8'h01);
        cpu_read("R5 green 255", 2'd2, 8'h02);
        cpu_read("R5 blue 255", 2'd2, 8'h03);
        cpu_read("R5 wrap index", 2'd1, 8'h00);

        // R3 / R6: partial triplet, then restart
        cpu_write(2'd1, 8'h20);
        cpu_write(2'd2, 8'h07);
        cpu_write(2'd2, 8'h08);
        pix_check("R3 no commit before blue", 8'h20, 18'h0);
        cpu_write(2'd1, 8'h20);
        cpu_write(2'd2, 8'h09);
        cpu_write(2'd2, 8'h0A);
        cpu_write(2'd2, 8'h0B);
        pix_check("R6 restart at red", 8'h20, 18'h0928B);

        // R6: read-sequence restart
        cpu_write(2'd0, 8'h10);
        cpu_read("R6 read red", 2'd2, 8'h05);
        cpu_write(2'd0, 8'h10);
        cpu_read("R6 read red again", 2'd2, 8'h05);

        // R8: data write in read mode ignored
        cpu_write(2'd0, 8'h10);
        cpu_write(2'd2, 8'h33);
        cpu_read("R8 index kept", 2'd1, 8'h10);
        pix_check("R8 entry kept", 8'h10, 18'h05A91);
        // R8: data read in write mode gives zero and no advance
        cpu_write(2'd1, 8'h30);
        cpu_read("R8 zero read", 2'd2, 8'h00);
        cpu_read("R8 index still", 2'd1, 8'h30);

        // R9: reserved address and write-wins
        cpu_write(2'd3, 8'hAA);
        cpu_read("R9 reserved", 2'd3, 8'h00);
        cpu_read("R9 index untouched", 2'd1, 8'h30);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_addr = 2'd1; cpu_wdata = 8'h44;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        cpu_read("R9 write wins", 2'd1, 8'h44);

        // R7: same-cycle commit and pixel read returns old value
        cpu_write(2'd1, 8'h40);
        cpu_write(2'd2, 8'h01);
        cpu_write(2'd2, 8'h01);
        @(negedge clk);
        pix_idx = 8'h40;
        cpu_wr = 1'b1; cpu_addr = 2'd2; cpu_wdata = 8'h01;
        @(negedge clk);
        cpu_wr = 1'b0;
        check18("R7 old value on collision", pix_rgb, 18'h0);
        @(negedge clk);
        check18("R7 new value next cycle", pix_rgb, 18'h01041);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule